// File: doc/BRIEF.md
# Flash Controller Interrupt Flag Unit

This block keeps the four event flags of a flash controller and merges them into a single interrupt request. The four events are end of operation, operation error, read error and ECC correction. Each arrives as a one-cycle pulse from the controller's operation logic. Each event has its own enable bit. These enable bits come from a control register held elsewhere and enter the block as a static mask.

The enable bit plays two roles, depending on the event:

- For end of operation and operation error, the enable decides whether the flag is recorded at all. A pulse that arrives while the enable is off leaves no trace.
- For read error and ECC correction, the flag is always recorded. The enable only decides whether the flag drives the interrupt line.

Software clears a flag by writing 1 to its bit on a small write port. Writing 0 to a bit leaves that flag unchanged. If a new event and a clear hit the same flag in the same cycle, the event wins, so the occurrence is not lost.

The flag and enable bit positions are the same everywhere in the block:

| Bit | Event |
|-----|-------|
| 0 | end of operation |
| 1 | operation error |
| 2 | read error |
| 3 | ECC correction |

Top module: `fif_unit`

## Requirements
- R1: An end-of-operation pulse (ev_pulse[0]) sets flags[0] one clock later only if irq_en[0] is 1. With irq_en[0] at 0, flags[0] stays unchanged.
- R2: An operation-error pulse (ev_pulse[1]) sets flags[1] one clock later only if irq_en[1] is 1. With irq_en[1] at 0, flags[1] stays unchanged.
- R3: A read-error pulse (ev_pulse[2]) sets flags[2] one clock later, whatever the value of irq_en[2].
- R4: An ECC-correction pulse (ev_pulse[3]) sets flags[3] one clock later, whatever the value of irq_en[3].
- R5: When clr_we is 1 and clr_data[i] is 1, flags[i] reads 0 one clock later, provided no set event hits that flag in the same cycle.
- R6: A clr_data bit of 0 has no effect on its flag, even while clr_we is 1.
- R7: When a set event and a clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R8: irq is 1 exactly when some bit i has both flags[i] and irq_en[i] at 1. irq follows the flags and irq_en with no extra register stage.
- R9: A synchronous active-high reset clears all four flags, so irq reads 0.
- R10: A flag that receives neither a set nor a clear keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_pulse | input | 4 | One-cycle event pulses: bit 0 end of operation, bit 1 operation error, bit 2 read error, bit 3 ECC correction |
| irq_en | input | 4 | Enable bit per event, same bit order as ev_pulse |
| clr_we | input | 1 | Write strobe of the flag-clear port |
| clr_data | input | 4 | Write-1-to-clear data, one bit per flag |
| flags | output | 4 | Current flag values |
| irq | output | 1 | Combined interrupt request |

## Verification
A flag responds to an event pulse or a clear exactly one rising edge after the cycle in which the pulse or write is presented. irq adds no register of its own, so it is due in the same cycle as the flags it depends on. The bench drives all inputs on the falling edge and waits through the next rising edge. It compares flags and irq at the following falling edge against a reference model that has been advanced by one step. Because irq is combinational, it is checked against the enable mask that is present at the moment of sampling.

// File: rtl/fif_pkg.sv
package fif_pkg;

    localparam int unsigned NFLAG = 4;

    typedef enum logic [1:0] {
        EV_DONE   = 2'd0,
        EV_OPFAIL = 2'd1,
        EV_RDFAIL = 2'd2,
        EV_ECCFIX = 2'd3
    } ev_e;

    // Events whose flag is only recorded when the enable bit is set
    localparam logic [NFLAG-1:0] SET_GATED = 4'b0011;

    typedef struct packed {
        logic eccfix;
        logic rdfail;
        logic opfail;
        logic done;
    } flagvec_t;

    function automatic logic set_allowed(logic ev, logic en, logic gated);
        return ev && (en || !gated);
    endfunction

    function automatic logic flag_next(logic cur, logic set_req, logic clr_req);
        if (set_req) return 1'b1;
        if (clr_req) return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/fif_cell.sv
module fif_cell #(
    parameter bit GATED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic en,
    input  logic clr,
    output logic q
);
    import fif_pkg::*;

    logic set_req;

    always_comb set_req = set_allowed(ev, en, GATED);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= flag_next(q, set_req, clr);
    end
endmodule

// File: rtl/fif_irq.sv
module fif_irq #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    always_comb irq_o = |(flag_i & en_i);
endmodule

// File: rtl/fif_unit.sv
module fif_unit
    import fif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] ev_pulse,
    input  logic [NFLAG-1:0] irq_en,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_data,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    flagvec_t          st;
    logic [NFLAG-1:0]  clr_vec;

    always_comb clr_vec = clr_data & {NFLAG{clr_we}};

    for (genvar i = 0; i < NFLAG; i++) begin : g_cell
        fif_cell #(.GATED(SET_GATED[i])) u_cell (
            .clk (clk),
            .rst (rst),
            .ev  (ev_pulse[i]),
            .en  (irq_en[i]),
            .clr (clr_vec[i]),
            .q   (st[i])
        );
    end

    always_comb flags = st;

    fif_irq #(.N(NFLAG)) u_irq (
        .flag_i (st),
        .en_i   (irq_en),
        .irq_o  (irq)
    );
endmodule

// File: rtl/fif_unit_chk.sv
module fif_unit_chk
    import fif_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NFLAG-1:0] ev_pulse,
    input logic [NFLAG-1:0] irq_en,
    input logic             clr_we,
    input logic [NFLAG-1:0] clr_data,
    input logic [NFLAG-1:0] flags,
    input logic             irq
);
    // R1
    assert_done_gated_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_pulse[0] && !irq_en[0] && !flags[0] && !(clr_we && clr_data[0])) |=> !flags[0]);

    // R2
    assert_opfail_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_pulse[1] && !irq_en[1] && !flags[1]) |=> !flags[1]);

    // R3
    assert_rdfail_set_R3: assert property (@(posedge clk) disable iff (rst)
        ev_pulse[2] |=> flags[2]);

    // R4
    assert_eccfix_set_R4: assert property (@(posedge clk) disable iff (rst)
        ev_pulse[3] |=> flags[3]);

    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        // R5
        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_data[i] && !ev_pulse[i]) |=> !flags[i]);

        // R7
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_data[i] && ev_pulse[i] && (irq_en[i] || !SET_GATED[i])) |=> flags[i]);

        // R6
        assert_zero_write_R6: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !(clr_we && clr_data[i])) |=> flags[i]);

        // R10
        assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (!flags[i] && !ev_pulse[i]) |=> !flags[i]);
    end

    // R8
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & irq_en) != '0));

    // R9
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (flags == '0));
endmodule

bind fif_unit fif_unit_chk u_fif_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_pulse (ev_pulse),
    .irq_en   (irq_en),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .flags    (flags),
    .irq      (irq)
);

// File: tb/fif_unit_bench.sv
`timescale 1ns/1ps
module fif_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ev_pulse, irq_en, clr_data;
    logic       clr_we;
    logic [3:0] flags;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] mdl = 4'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fif_unit u_fif_unit (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .irq_en(irq_en),
        .clr_we(clr_we), .clr_data(clr_data), .flags(flags), .irq(irq)
    );

    // Reference step: bits 0,1 need enable to set; bits 2,3 always set; set beats clear.
    function automatic logic [3:0] ref_step(logic [3:0] cur, logic [3:0] ev,
                                            logic [3:0] en, logic we, logic [3:0] cd);
        logic [3:0] nxt;
        for (int b = 0; b < 4; b++) begin
            logic s;
            s = ev[b] && ((b >= 2) || en[b]);
            if (s)                nxt[b] = 1'b1;
            else if (we && cd[b]) nxt[b] = 1'b0;
            else                  nxt[b] = cur[b];
        end
        return nxt;
    endfunction

    function automatic logic ref_irq(logic [3:0] f, logic [3:0] en);
        return (f & en) != 4'b0;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic apply(logic [3:0] ev, logic [3:0] en, logic we, logic [3:0] cd);
        ev_pulse = ev; irq_en = en; clr_we = we; clr_data = cd;
        mdl = ref_step(mdl, ev, en, we, cd);
        @(posedge clk);
        @(negedge clk);
        ev_pulse = 4'b0; clr_we = 1'b0; clr_data = 4'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ev_pulse = 0; irq_en = 0; clr_we = 0; clr_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl = 4'b0;
        check("R9 flags after reset", flags, 4'b0);
        check("R9 irq after reset", {3'b0, irq}, 4'b0);

        // R1: gated end-of-operation
        apply(4'b0001, 4'b0000, 0, 0);
        check("R1 done ignored when disabled", flags, 4'b0000);
        apply(4'b0001, 4'b0001, 0, 0);
        check("R1 done recorded when enabled", flags, 4'b0001);
        check("R8 irq with done enabled", {3'b0, irq}, 4'b0001);
        apply(4'b0000, 4'b0001, 1, 4'b0001);
        check("R5 clear done", flags, 4'b0000);

        // R2: gated operation error
        apply(4'b0010, 4'b0000, 0, 0);
        check("R2 opfail ignored when disabled", flags, 4'b0000);
        apply(4'b0010, 4'b0010, 0, 0);
        check("R2 opfail recorded when enabled", flags, 4'b0010);
        apply(4'b0000, 4'b0000, 1, 4'b0010);
        check("R5 clear opfail", flags, 4'b0000);

        // R3/R4: ungated, irq masked
        apply(4'b0100, 4'b0000, 0, 0);
        check("R3 rdfail recorded when disabled", flags, 4'b0100);
        check("R8 irq masked", {3'b0, irq}, 4'b0000);
        apply(4'b1000, 4'b0000, 0, 0);
        check("R4 eccfix recorded when disabled", flags, 4'b1100);
        irq_en = 4'b1000;
        #1;
        check("R8 irq follows enable", {3'b0, irq}, 4'b0001);

        // R6: zero bits of write leave flags
        apply(4'b0000, 4'b1000, 1, 4'b0011);
        check("R6 zero write no effect", flags, 4'b1100);
        // R10: idle hold
        apply(4'b0000, 4'b0000, 0, 4'b0000);
        check("R10 hold", flags, 4'b1100);
        // R7: set wins over clear
        apply(4'b0100, 4'b0000, 1, 4'b1100);
        check("R7 set beats clear", flags, 4'b0100);
        apply(4'b0001, 4'b0001, 1, 4'b0101);
        check("R7 set beats clear gated", flags, 4'b0001);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] ev, en, cd;
            logic we;
            ev = 4'($urandom);
            en = 4'($urandom);
            we = ($urandom % 3) == 0;
            cd = 4'($urandom);
            apply(ev, en, we, cd);
            check("R1 random bit0", {3'b0, flags[0]}, {3'b0, mdl[0]});
            check("R2 random bit1", {3'b0, flags[1]}, {3'b0, mdl[1]});
            check("R3 random bit2", {3'b0, flags[2]}, {3'b0, mdl[2]});
            check("R4 random bit3", {3'b0, flags[3]}, {3'b0, mdl[3]});
            check("R8 random irq", {3'b0, irq}, {3'b0, ref_irq(mdl, irq_en)});
        end

        // R9: reset mid-run
        apply(4'b1111, 4'b1111, 0, 0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0; mdl = 4'b0;
        check("R9 flags after mid-run reset", flags, 4'b0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule